// File: doc/BRIEF.md
# Internal Data Memory and Register-Space Decoder

This block holds the 256-byte internal scratch RAM of an 8-bit microcontroller and routes each data access either to that RAM or to an external bus for peripheral control registers. Every access carries an 8-bit address and a mode flag that says whether the address came from an instruction operand (direct) or from a pointer register (indirect).

In the lower half of the address space both modes reach the same RAM bytes. In the upper half the two modes split. Direct accesses go out on the register bus and never touch RAM. Indirect accesses reach the upper 128 bytes of RAM, and the register bus stays idle.

Writes take effect at the clock edge that samples them. Reads present their byte, together with a one-cycle valid pulse, after the following clock edge. A register read whose address has no register behind it returns zero.

Top module: `iram_sfr_decode`

## Requirements
- R1: An indirect access (`acc_ind`=1) at any address 00h–FFh writes or reads the RAM byte at that address.
- R2: A direct access (`acc_ind`=0) at an address below 80h (bit 7 = 0) reaches the same RAM byte that an indirect access to that address reaches.
- R3: A direct access at 80h–FFh (bit 7 = 1) drives `sfr_sel`=1 in the same cycle, with `sfr_addr` equal to the access address. On a write it also drives `sfr_we`=1 and `sfr_wdata` equal to the write data. Such an access leaves the RAM unchanged.
- R4: An indirect access never asserts `sfr_sel` or `sfr_we`, including at 80h–FFh.
- R5: A read (`acc_en`=1, `acc_we`=0) places its byte on `acc_rdata` and pulses `acc_rvalid` high for exactly one cycle after the next rising clock edge. In every other cycle `acc_rvalid` is low.
- R6: On a direct register read, `acc_rdata` takes the value of `sfr_rdata` when `sfr_hit`=1, and 00h when `sfr_hit`=0.
- R7: While `rst_n` is low, `sfr_sel`, `sfr_we`, `sfr_addr`, `sfr_wdata`, `acc_rvalid` and `acc_rdata` are all zero. RAM contents survive reset.
- R8: `acc_rdata` keeps the value of the last read through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access request in this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_ind | input | 1 | 1 = indirect, 0 = direct addressing |
| acc_addr | input | 8 | Access address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, registered |
| acc_rvalid | output | 1 | One-cycle pulse marking new read data |
| sfr_sel | output | 1 | Register bus select |
| sfr_we | output | 1 | Register bus write strobe |
| sfr_addr | output | 8 | Register bus address |
| sfr_wdata | output | 8 | Register bus write data |
| sfr_rdata | input | 8 | Register bus read data, same cycle as select |
| sfr_hit | input | 1 | A register exists at `sfr_addr` |

## Verification
A mistake in the decode shows at the ports in two ways. A wrong select appears in the same cycle as the request. A wrong write into RAM stays hidden until the affected byte is read back. For that reason, every direct write to the upper half is followed later by an indirect read of the same address, which would return the corrupted byte one cycle after that read. Faults in the read path show one cycle after the read request, either as a wrong byte on `acc_rdata` or as a missing or extra `acc_rvalid` pulse.

// File: rtl/iram_sfr_decode.sv
module iram_sfr_decode #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic          acc_ind,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic          acc_rvalid,
  output logic          sfr_sel,
  output logic          sfr_we,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata,
  input  logic          sfr_hit
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  wire to_sfr = acc_en & ~acc_ind & acc_addr[AW-1];
  wire to_ram = acc_en & ~to_sfr;
  wire rd     = acc_en & ~acc_we;

  assign sfr_sel   = to_sfr & rst_n;
  assign sfr_we    = to_sfr & acc_we & rst_n;
  assign sfr_addr  = sfr_sel ? acc_addr : '0;
  assign sfr_wdata = sfr_we ? acc_wdata : '0;

  always_ff @(posedge clk)
    if (to_ram && acc_we) mem[acc_addr] <= acc_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc_rdata  <= '0;
      acc_rvalid <= 1'b0;
    end else begin
      acc_rvalid <= rd;
      if (rd) acc_rdata <= to_sfr ? (sfr_hit ? sfr_rdata : '0) : mem[acc_addr];
    end

  p_rvalid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we) |=> acc_rvalid);
  p_rvalid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_we) |=> !acc_rvalid);
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_sel && !sfr_we && !sfr_hit) |=> acc_rdata == '0);
  p_hit_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_sel && !sfr_we && sfr_hit) |=> acc_rdata == $past(sfr_rdata));
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_we) |=> $stable(acc_rdata));
  p_no_bus_indirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ind |-> !sfr_sel && !sfr_we);
endmodule

// File: tb/iram_sfr_decode_tb_top.sv
module iram_sfr_decode_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_en = 0, acc_we = 0, acc_ind = 0;
  logic [7:0] acc_addr = 0, acc_wdata = 0;
  logic [7:0] acc_rdata, sfr_addr, sfr_wdata, sfr_rdata;
  logic acc_rvalid, sfr_sel, sfr_we, sfr_hit;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  assign sfr_rdata = sfr_addr ^ 8'hC3;
  assign sfr_hit   = (sfr_addr % 3) != 0;

  iram_sfr_decode dut_i (.*);

  function automatic logic [7:0] pat_f(input int a); return 8'((a * 7 + 3) ^ 8'h5A); endfunction
  function automatic logic [7:0] pat_g(input int a); return ~pat_f(a); endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic ind, input int a, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = we; acc_ind = ind; acc_addr = 8'(a); acc_wdata = d;
  endtask

  task automatic idle_and_read(output logic [7:0] rd, output logic v);
    @(negedge clk);
    rd = acc_rdata; v = acc_rvalid;
    acc_en = 0; acc_we = 0;
  endtask

  task automatic ram_read(input logic ind, input int a, input logic [7:0] exp, input string req);
    logic [7:0] rd; logic v;
    access(0, ind, a, 8'h00);
    #1 chk({req, " bus idle"}, {7'b0, sfr_sel}, 8'h00);
    idle_and_read(rd, v);
    chk(req, rd, exp);
    chk("R5 rvalid", {7'b0, v}, 8'h01);
  endtask

  initial begin
    logic [7:0] rd; logic v;
    #5;
    chk("R7 sel", {7'b0, sfr_sel}, 0);
    chk("R7 we", {7'b0, sfr_we}, 0);
    chk("R7 rdata", acc_rdata, 0);
    chk("R7 rvalid", {7'b0, acc_rvalid}, 0);
    acc_en = 1; acc_ind = 0; acc_addr = 8'h90; #1;
    chk("R7 sel gated", {7'b0, sfr_sel}, 0);
    chk("R7 addr gated", sfr_addr, 0);
    acc_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int a = 0; a < 256; a++) begin
      access(1, 1, a, pat_f(a));
      #1 chk("R4 no sel on indirect write", {7'b0, sfr_sel}, 0);
      chk("R4 no we on indirect write", {7'b0, sfr_we}, 0);
    end
    @(negedge clk) acc_en = 0;
    chk("R5 no rvalid after write", {7'b0, acc_rvalid}, 0);
    for (int a = 0; a < 256; a++) ram_read(1, a, pat_f(a), "R1 indirect read");

    for (int a = 0; a < 128; a++) ram_read(0, a, pat_f(a), "R2 direct lower read");
    for (int a = 0; a < 128; a++) access(1, 0, a, pat_g(a));
    for (int a = 0; a < 128; a++) ram_read(1, a, pat_g(a), "R2 shared lower");

    for (int a = 128; a < 256; a++) begin
      access(1, 0, a, 8'(a ^ 8'h3C));
      #1;
      chk("R3 sel", {7'b0, sfr_sel}, 1);
      chk("R3 we", {7'b0, sfr_we}, 1);
      chk("R3 addr", sfr_addr, 8'(a));
      chk("R3 wdata", sfr_wdata, 8'(a ^ 8'h3C));
    end
    idle_and_read(rd, v);
    chk("R5 no rvalid after bus write", {7'b0, v}, 0);
    for (int a = 128; a < 256; a++) ram_read(1, a, pat_f(a), "R3 R4 upper RAM untouched");

    for (int a = 128; a < 256; a++) begin
      access(0, 0, a, 8'h00);
      #1 chk("R3 read sel", {7'b0, sfr_sel}, 1);
      chk("R3 read we low", {7'b0, sfr_we}, 0);
      idle_and_read(rd, v);
      chk("R6 bus read", rd, (a % 3 != 0) ? 8'(a ^ 8'hC3) : 8'h00);
      chk("R5 bus rvalid", {7'b0, v}, 1);
    end

    ram_read(1, 8'h41, pat_g(8'h41), "R8 setup");
    access(1, 1, 8'h42, 8'hEE);
    idle_and_read(rd, v);
    chk("R8 hold after write", rd, pat_g(8'h41));
    chk("R5 rvalid low on write", {7'b0, v}, 0);
    @(negedge clk);
    chk("R8 hold idle", acc_rdata, pat_g(8'h41));

    access(1, 0, 8'hA0, 8'h77);
    rst_n = 0; #1;
    chk("R7 sel low in reset", {7'b0, sfr_sel}, 0);
    chk("R7 wdata low in reset", sfr_wdata, 0);
    chk("R7 rdata cleared", acc_rdata, 0);
    acc_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    ram_read(1, 8'h42, 8'hEE, "R7 RAM retained");
    ram_read(1, 8'hC5, pat_f(8'hC5), "R7 upper retained");
    ram_read(0, 8'h10, pat_g(8'h10), "R7 lower retained");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule